// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block lets a processor reach a configuration register space that is not mapped on its own control-register bus. The processor sees three words at fixed offsets from a base address: a data word, a command word carrying a target address plus a direction flag, and a status word with one completion flag for reads and one for writes. Writing the command word launches exactly one access to the internal space. The bridge runs that access over a request/acknowledge handshake whose latency is not bounded. It then raises the flag for the direction that finished.

To read, software writes the target address with the direction flag clear, polls the status word until the read flag is set, and then fetches the result from the data word. To write, software first loads the value into the data word, then writes the address with the direction flag set, and polls for the write flag. Addresses outside a parameterised window are not sent to the internal side. They complete locally one cycle later, and a read of such an address yields zero. A command written while an access is still running is dropped.

Top module: `ind_cfg_bridge`

## Requirements
- R1: Only host addresses BASE_ADDR+13 (data word), BASE_ADDR+14 (command word) and BASE_ADDR+15 (status word) are decoded. Reads elsewhere return zero and writes elsewhere change nothing. The command word reads back with the direction flag at bit 15, the address in bits CFG_ADDR_W-1:0, and zeros in all other bits.
- R2: Writing the command word with bit 15 clear to an in-window address raises cfg_req on the following clock, with cfg_wr low and cfg_addr equal to bits CFG_ADDR_W-1:0 of the written word.
- R3: Writing the command word with bit 15 set starts a write. cfg_wr is high and cfg_wdata carries the data word value held when the command was written, even if the host rewrites the data word while the access is pending.
- R4: cfg_req stays high with cfg_addr, cfg_wr and cfg_wdata unchanged until a clock on which cfg_ack is high, and it is low on the clock after that.
- R5: When a read completes, the data word takes the returned cfg_rdata on the same clock edge on which status bit 5 (read-ready, mask 0x20) becomes 1.
- R6: When a write completes, status bit 14 (write-ready, mask 0x4000) becomes 1.
- R7: An accepted command-word write clears both status flags on the next clock.
- R8: A command-word write while an access is pending is ignored: the command word, the internal request and the number of handshakes are unaffected.
- R9: A completion flag stays set until the next accepted command-word write. Reading the status or data word does not alter either of them. At most one flag is set.
- R10: An address outside MAP_LO..MAP_HI produces no cfg_req. Its flag is set two clocks after the command write, a read of it returns zero, and a write to it is discarded.
- R11: After reset the data word, command word and status word read zero and cfg_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host bus cycle select |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | HADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| cfg_req | output | 1 | Internal access request, held until acknowledged |
| cfg_wr | output | 1 | Internal access is a write |
| cfg_addr | output | CFG_ADDR_W | Internal register address |
| cfg_wdata | output | DATA_W | Internal write data |
| cfg_ack | input | 1 | Internal access done, one clock pulse |
| cfg_rdata | input | DATA_W | Internal read data, valid with cfg_ack |

## Verification
The hardest case to reach from the ports is a second command write that lands while the internal side is still stalled. The stimulus must also check that the pending request, the stored command and the handshake count all stay unchanged. The bench gets there with a model of the internal register file that has a hold switch on top of its random acknowledge delay. With the hold on, it issues the competing command write and rewrites the data word, samples the request lines over several cycles, and then releases the hold. The local-completion path for out-of-window addresses is timed to the exact cycle against that same model.

// File: rtl/ind_cfg_pkg.sv
package ind_cfg_pkg;
   localparam int unsigned OFS_DATA     = 13;
   localparam int unsigned OFS_CTRL     = 14;
   localparam int unsigned OFS_STAT     = 15;
   localparam int unsigned CTRL_DIR_BIT = 15;
   localparam int unsigned STAT_RD_BIT  = 5;
   localparam int unsigned STAT_WR_BIT  = 14;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_BUS   = 2'd1,
      SEQ_LOCAL = 2'd2
   } seq_state_e;
endpackage

// File: rtl/icb_host_decode.sv
module icb_host_decode
   import ind_cfg_pkg::*;
#(
   parameter int                 HADDR_W   = 10,
   parameter logic [HADDR_W-1:0] BASE_ADDR = 10'h040
) (
   input  logic               host_sel,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   output logic               rd_data,
   output logic               rd_ctrl,
   output logic               rd_stat,
   output logic               wr_data,
   output logic               wr_ctrl
);
   localparam logic [HADDR_W-1:0] A_DATA = BASE_ADDR + HADDR_W'(OFS_DATA);
   localparam logic [HADDR_W-1:0] A_CTRL = BASE_ADDR + HADDR_W'(OFS_CTRL);
   localparam logic [HADDR_W-1:0] A_STAT = BASE_ADDR + HADDR_W'(OFS_STAT);

   initial begin
      assert (int'(BASE_ADDR) + int'(OFS_STAT) < (1 << HADDR_W))
         else $error("register window does not fit the host address width");
   end

   logic hit_data, hit_ctrl, hit_stat;

   assign hit_data = host_sel && (host_addr == A_DATA);
   assign hit_ctrl = host_sel && (host_addr == A_CTRL);
   assign hit_stat = host_sel && (host_addr == A_STAT);

   assign rd_data  = hit_data && !host_we;
   assign rd_ctrl  = hit_ctrl && !host_we;
   assign rd_stat  = hit_stat && !host_we;
   assign wr_data  = hit_data && host_we;
   assign wr_ctrl  = hit_ctrl && host_we;
endmodule

// File: rtl/icb_access_seq.sv
module icb_access_seq
   import ind_cfg_pkg::*;
#(
   parameter int                    DATA_W     = 32,
   parameter int                    CFG_ADDR_W = 11,
   parameter bit                    CHECK_MAP  = 1'b1,
   parameter logic [CFG_ADDR_W-1:0] MAP_LO     = 11'h200,
   parameter logic [CFG_ADDR_W-1:0] MAP_HI     = 11'h6FF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  start_wr,
   input  logic [CFG_ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0]     start_wdata,
   output logic                  busy,
   output logic                  cfg_req,
   output logic                  cfg_wr,
   output logic [CFG_ADDR_W-1:0] cfg_addr,
   output logic [DATA_W-1:0]     cfg_wdata,
   input  logic                  cfg_ack,
   input  logic [DATA_W-1:0]     cfg_rdata,
   output logic                  done_rd,
   output logic                  done_wr,
   output logic [DATA_W-1:0]     done_rdata
);
   seq_state_e            state_q;
   logic                  wr_q;
   logic [CFG_ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0]     wdata_q;
   logic                  in_map;
   logic                  finish;

   generate
      if (CHECK_MAP) begin : g_window
         assign in_map = (start_addr >= MAP_LO) && (start_addr <= MAP_HI);
      end else begin : g_flat
         assign in_map = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  wr_q    <= start_wr;
                  addr_q  <= start_addr;
                  wdata_q <= start_wdata;
                  state_q <= in_map ? SEQ_BUS : SEQ_LOCAL;
               end
            end
            SEQ_BUS:   if (cfg_ack) state_q <= SEQ_IDLE;
            SEQ_LOCAL: state_q <= SEQ_IDLE;
            default:   state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != SEQ_IDLE);
   assign cfg_req    = (state_q == SEQ_BUS);
   assign cfg_wr     = wr_q;
   assign cfg_addr   = addr_q;
   assign cfg_wdata  = wdata_q;
   assign finish     = (cfg_req && cfg_ack) || (state_q == SEQ_LOCAL);
   assign done_rd    = finish && !wr_q;
   assign done_wr    = finish && wr_q;
   assign done_rdata = cfg_req ? cfg_rdata : '0;

   assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_wr)
                                 && $stable(cfg_wdata)));
   assert_req_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_ack) |=> !cfg_req);
   assert_local_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cfg_req) |=> !busy);

   generate
      if (CHECK_MAP) begin : g_map_chk
         assert_req_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_req |-> ((cfg_addr >= MAP_LO) && (cfg_addr <= MAP_HI)));
      end
   endgenerate
endmodule

// File: rtl/ind_cfg_bridge.sv
module ind_cfg_bridge
   import ind_cfg_pkg::*;
#(
   parameter int                    HADDR_W     = 10,
   parameter logic [HADDR_W-1:0]    BASE_ADDR   = 10'h040,
   parameter int                    DATA_W      = 32,
   parameter int                    CFG_ADDR_W  = 11,
   parameter bit                    CHECK_MAP   = 1'b1,
   parameter logic [CFG_ADDR_W-1:0] MAP_LO      = 11'h200,
   parameter logic [CFG_ADDR_W-1:0] MAP_HI      = 11'h6FF,
   parameter bit                    HOST_RD_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_sel,
   input  logic                  host_we,
   input  logic [HADDR_W-1:0]    host_addr,
   input  logic [DATA_W-1:0]     host_wdata,
   output logic [DATA_W-1:0]     host_rdata,
   output logic                  cfg_req,
   output logic                  cfg_wr,
   output logic [CFG_ADDR_W-1:0] cfg_addr,
   output logic [DATA_W-1:0]     cfg_wdata,
   input  logic                  cfg_ack,
   input  logic [DATA_W-1:0]     cfg_rdata
);
   initial begin
      assert (DATA_W >= 16) else $error("DATA_W must hold the command and status bits");
      assert (CFG_ADDR_W >= 1 && CFG_ADDR_W <= 15) else $error("CFG_ADDR_W out of range");
      assert (MAP_LO <= MAP_HI) else $error("mapped window is empty");
   end

   logic                  rd_data, rd_ctrl, rd_stat, wr_data, wr_ctrl;
   logic                  busy, start;
   logic                  done_rd, done_wr;
   logic [DATA_W-1:0]     done_rdata;
   logic [DATA_W-1:0]     data_q;
   logic [CFG_ADDR_W-1:0] addr_q;
   logic                  dir_q, rd_rdy_q, wr_rdy_q;
   logic [DATA_W-1:0]     rd_word;
   logic                  wdata_unused;

   assign wdata_unused = ^host_wdata;

   icb_host_decode #(
      .HADDR_W   (HADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_decode (
      .host_sel  (host_sel),
      .host_we   (host_we),
      .host_addr (host_addr),
      .rd_data   (rd_data),
      .rd_ctrl   (rd_ctrl),
      .rd_stat   (rd_stat),
      .wr_data   (wr_data),
      .wr_ctrl   (wr_ctrl)
   );

   assign start = wr_ctrl && !busy;

   icb_access_seq #(
      .DATA_W     (DATA_W),
      .CFG_ADDR_W (CFG_ADDR_W),
      .CHECK_MAP  (CHECK_MAP),
      .MAP_LO     (MAP_LO),
      .MAP_HI     (MAP_HI)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_wr    (host_wdata[CTRL_DIR_BIT]),
      .start_addr  (host_wdata[CFG_ADDR_W-1:0]),
      .start_wdata (data_q),
      .busy        (busy),
      .cfg_req     (cfg_req),
      .cfg_wr      (cfg_wr),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .cfg_ack     (cfg_ack),
      .cfg_rdata   (cfg_rdata),
      .done_rd     (done_rd),
      .done_wr     (done_wr),
      .done_rdata  (done_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q   <= '0;
         addr_q   <= '0;
         dir_q    <= 1'b0;
         rd_rdy_q <= 1'b0;
         wr_rdy_q <= 1'b0;
      end else begin
         if (start) begin
            dir_q    <= host_wdata[CTRL_DIR_BIT];
            addr_q   <= host_wdata[CFG_ADDR_W-1:0];
            rd_rdy_q <= 1'b0;
            wr_rdy_q <= 1'b0;
         end
         if (done_rd) rd_rdy_q <= 1'b1;
         if (done_wr) wr_rdy_q <= 1'b1;
         if (done_rd)      data_q <= done_rdata;
         else if (wr_data) data_q <= host_wdata;
      end
   end

   always_comb begin
      rd_word = '0;
      if (rd_data) begin
         rd_word = data_q;
      end else if (rd_ctrl) begin
         rd_word[CFG_ADDR_W-1:0] = addr_q;
         rd_word[CTRL_DIR_BIT]   = dir_q;
      end else if (rd_stat) begin
         rd_word[STAT_RD_BIT] = rd_rdy_q;
         rd_word[STAT_WR_BIT] = wr_rdy_q;
      end
   end

   generate
      if (HOST_RD_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_word;
         end
         assign host_rdata = rdata_q;
      end else begin : g_rd_comb
         assign host_rdata = rd_word;
      end
   endgenerate

   assert_read_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_rd |=> (rd_rdy_q && (data_q == $past(done_rdata))));
   assert_write_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_wr |=> wr_rdy_q);
   assert_flags_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!rd_rdy_q && !wr_rdy_q));
   assert_busy_ignores_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && busy) |=> ($stable(addr_q) && $stable(dir_q)));
   assert_flag_persists_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_rdy_q || wr_rdy_q) && !start) |=> ($stable(rd_rdy_q) && $stable(wr_rdy_q)));
   assert_single_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_rdy_q, wr_rdy_q}));
endmodule

// File: tb/ind_cfg_bridge_tb.sv
module ind_cfg_bridge_tb;
   localparam int          CLK_PERIOD = 10;
   localparam int          MAX_LAT    = 6;
   localparam logic [9:0]  BASE       = 10'h040;
   localparam logic [10:0] MAP_LO     = 11'h200;
   localparam logic [10:0] MAP_HI     = 11'h6FF;
   localparam logic [9:0]  A_DATA     = BASE + 10'd13;
   localparam logic [9:0]  A_CTRL     = BASE + 10'd14;
   localparam logic [9:0]  A_STAT     = BASE + 10'd15;
   localparam logic [31:0] M_RD       = 32'h0000_0020;
   localparam logic [31:0] M_WR       = 32'h0000_4000;

   // {write, address, value}
   localparam logic [43:0] VECS [0:8] = '{
      {1'b1, 11'h6C0, 32'h6000_0000},
      {1'b1, 11'h280, 32'h0000_0A5C},
      {1'b0, 11'h280, 32'h0},
      {1'b0, 11'h6C0, 32'h0},
      {1'b1, 11'h6FF, 32'hFFFF_FFFF},
      {1'b0, 11'h6FF, 32'h0},
      {1'b1, 11'h7FF, 32'h1234_5678},
      {1'b0, 11'h7FF, 32'h0},
      {1'b0, 11'h200, 32'h0}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        host_sel = 1'b0, host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        cfg_req, cfg_wr, cfg_ack = 1'b0;
   logic [10:0] cfg_addr;
   logic [31:0] cfg_wdata, cfg_rdata = '0;

   int checks = 0, errors = 0, hs_count = 0, cnt = 0;
   bit stall = 1'b0, srv = 1'b0, hung = 1'b0;
   logic [31:0] mem    [0:2047];
   bit          mem_wr [0:2047];
   logic [31:0] shadow [0:2047];

   ind_cfg_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] seed_val(input int a);
      return 32'h1000_0000 + 32'(a) * 32'h0001_0101;
   endfunction

   // internal register file model with random acknowledge delay and a hold switch
   always @(negedge clk) begin
      if (cfg_ack) begin
         cfg_ack <= 1'b0;
         srv     <= 1'b0;
      end else if (cfg_req && !srv) begin
         srv <= 1'b1;
         cnt <= $urandom_range(0, MAX_LAT);
      end else if (cfg_req && !stall) begin
         if (cnt == 0) begin
            cfg_ack <= 1'b1;
            if (cfg_wr) begin
               mem[cfg_addr]    <= cfg_wdata;
               mem_wr[cfg_addr] <= 1'b1;
            end else begin
               cfg_rdata <= mem_wr[cfg_addr] ? mem[cfg_addr] : seed_val(int'(cfg_addr));
            end
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   always @(posedge clk) if (cfg_req && cfg_ack) hs_count <= hs_count + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic rd_now(input logic [9:0] a, output logic [31:0] d);
      host_sel = 1'b1; host_we = 1'b0; host_addr = a;
      #1 d = host_rdata;
      host_sel = 1'b0;
   endtask

   task automatic host_rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_now(a, d);
   endtask

   task automatic host_wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
   endtask

   task automatic poll(input logic [31:0] mask, output logic [31:0] st, output logic [31:0] dt);
      st = '0; dt = '0;
      for (int k = 0; k < 64; k++) begin
         host_rd(A_STAT, st);
         rd_now(A_DATA, dt);
         if ((st & mask) != 0) break;
      end
   endtask

   task automatic run_all();
      logic [31:0] st, dt;
      int hs0;
      for (int i = 0; i < 2048; i++) shadow[i] = seed_val(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      chk("R11 cfg_req after reset", {31'b0, cfg_req}, 32'h0);
      host_rd(A_DATA, dt); chk("R11 data word after reset", dt, 32'h0);
      host_rd(A_CTRL, dt); chk("R11 command word after reset", dt, 32'h0);
      host_rd(A_STAT, dt); chk("R11 status word after reset", dt, 32'h0);

      // R1 decode
      host_rd(A_DATA - 10'd1, dt); chk("R1 offset 12 reads zero", dt, 32'h0);
      host_rd(A_STAT + 10'd1, dt); chk("R1 offset 16 reads zero", dt, 32'h0);
      host_rd(10'd13, dt);         chk("R1 base not added reads zero", dt, 32'h0);
      hs0 = hs_count;
      host_wr(A_DATA + 10'd3, 32'hFFFF_FFFF);
      host_wr(10'd14, 32'h0000_0280);
      host_rd(A_DATA, dt); chk("R1 stray writes leave data word", dt, 32'h0);
      host_rd(A_CTRL, dt); chk("R1 stray writes leave command word", dt, 32'h0);
      chk("R1 stray writes start nothing", 32'(hs_count - hs0), 32'h0);

      // vector walk
      for (int i = 0; i < 9; i++) begin
         logic        w;
         logic [10:0] a;
         logic [31:0] v;
         bit          mapped;
         {w, a, v} = VECS[i];
         mapped = (a >= MAP_LO) && (a <= MAP_HI);
         hs0 = hs_count;
         if (w) begin
            host_wr(A_DATA, v);
            host_wr(A_CTRL, 32'h0000_8000 | 32'(a));
            poll(M_WR, st, dt);
            chk("R6 write-ready status", st, M_WR);
            if (mapped) begin
               shadow[a] = v;
               chk("R3 target holds written value", mem[a], v);
               chk("R3 one handshake per write", 32'(hs_count - hs0), 32'h1);
            end else begin
               chk("R10 unmapped write discarded", {31'b0, mem_wr[a]}, 32'h0);
               chk("R10 unmapped write no handshake", 32'(hs_count - hs0), 32'h0);
            end
         end else begin
            host_wr(A_CTRL, 32'(a));
            poll(M_RD, st, dt);
            chk("R5 read-ready status", st, M_RD);
            chk(mapped ? "R5 read data" : "R10 unmapped read zero", dt, mapped ? shadow[a] : 32'h0);
            chk(mapped ? "R2 one handshake per read" : "R10 unmapped read no handshake",
                32'(hs_count - hs0), mapped ? 32'h1 : 32'h0);
         end
      end

      // R1 command readback drops unused bits
      host_wr(A_DATA, 32'h0000_00F0);
      host_wr(A_CTRL, 32'hABCD_F6C0);
      host_rd(A_CTRL, dt); chk("R1 command readback", dt, 32'h0000_86C0);
      poll(M_WR, st, dt);
      shadow[11'h6C0] = 32'h0000_00F0;
      chk("R6 write-ready after masked command", st, M_WR);

      // R2 R4 R7 R8 with the internal side stalled
      stall = 1'b1;
      hs0 = hs_count;
      host_wr(A_CTRL, 32'h0000_0280);
      chk("R2 request raised", {31'b0, cfg_req}, 32'h1);
      chk("R2 read direction", {31'b0, cfg_wr}, 32'h0);
      chk("R2 request address", 32'(cfg_addr), 32'h280);
      rd_now(A_STAT, st); chk("R7 flags cleared by command", st, 32'h0);
      host_wr(A_CTRL, 32'h0000_86C0);
      host_rd(A_CTRL, dt); chk("R8 command word unchanged while busy", dt, 32'h0000_0280);
      repeat (5) @(negedge clk);
      chk("R4 request still held", {31'b0, cfg_req}, 32'h1);
      chk("R4 address held", 32'(cfg_addr), 32'h280);
      chk("R4 direction held", {31'b0, cfg_wr}, 32'h0);
      stall = 1'b0;
      poll(M_RD, st, dt);
      chk("R5 stalled read status", st, M_RD);
      chk("R5 stalled read data", dt, shadow[11'h280]);
      repeat (12) @(negedge clk);
      chk("R8 no second access", 32'(hs_count - hs0), 32'h1);
      chk("R4 request dropped after ack", {31'b0, cfg_req}, 32'h0);

      // R9 persistence, no side effects of reads
      for (int k = 0; k < 3; k++) begin
         host_rd(A_STAT, st); chk("R9 read flag persists", st, M_RD);
         rd_now(A_DATA, dt);  chk("R9 data word persists", dt, shadow[11'h280]);
      end

      // R3 write data captured at command time
      stall = 1'b1;
      host_wr(A_DATA, 32'hCAFE_0001);
      host_wr(A_CTRL, 32'h0000_8280);
      chk("R3 write direction", {31'b0, cfg_wr}, 32'h1);
      chk("R3 write data presented", cfg_wdata, 32'hCAFE_0001);
      host_wr(A_DATA, 32'h0BAD_0BAD);
      chk("R4 write data held", cfg_wdata, 32'hCAFE_0001);
      stall = 1'b0;
      poll(M_WR, st, dt);
      chk("R6 stalled write status", st, M_WR);
      chk("R3 captured value stored", mem[11'h280], 32'hCAFE_0001);
      chk("R3 later data word kept", dt, 32'h0BAD_0BAD);
      shadow[11'h280] = 32'hCAFE_0001;

      // R10 local completion timing
      hs0 = hs_count;
      host_wr(A_DATA, 32'h0000_0055);
      host_wr(A_CTRL, 32'h0000_0100);
      rd_now(A_STAT, st); chk("R10 flag not set one clock after", st, 32'h0);
      host_rd(A_STAT, st); chk("R10 flag set two clocks after", st, M_RD);
      rd_now(A_DATA, dt);  chk("R10 unmapped read zero", dt, 32'h0);
      chk("R10 no request issued", 32'(hs_count - hs0), 32'h0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            hung = 1'b1;
         end
      join_any
      disable fork;
      if (hung) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule